// File: doc/BRIEF.md
# Directory coherence controller

This block is the home directory for one slice of the physical address space, shared by a group of private caches. Each cache sends three kinds of request on a single request port: read-miss, write-miss and evict. The directory keeps a small set-associative table of tracked lines. Each entry holds a tag, a state bit (Shared or exclusively owned) and a full bit vector of holders. An entry that is not valid means the line is Invalid.

Each read-miss or write-miss produces one coherence message, or two when a table entry must be recalled first. The message goes out on a valid/ready port. It carries a kind, the line address, a destination mask of caches and the requester id. The directory then stays busy until the fabric returns a completion pulse. Evicts update the table in a single cycle and send nothing. When a new line needs a slot in a full set, the least-recently-used entry is displaced, and every cache holding that line is told to drop it.

Top module: `dir_coherence_ctrl`

## Requirements
- R1: A read-miss (req_type 0) to an untracked line sends kind 0 (lower-level fetch, exclusive grant), with msg_dst all zero, msg_addr the request address and msg_req the requester. The line is then held by the requester alone as exclusive owner.
- R2: A read-miss to a Shared line sends kind 2 (forward read) to the lowest-numbered holder other than the requester, and adds the requester to the holders.
- R3: A read-miss to an exclusively owned line sends kind 2 to the owner, and the line becomes Shared by owner and requester.
- R4: A write-miss (req_type 1) to an untracked line sends kind 1 (lower-level fetch, modified grant) with msg_dst all zero.
- R5: A write-miss to a Shared line sends kind 4 (invalidate) with msg_dst set to every holder except the requester. The lowest bit of that mask names the cache that supplies the data. Afterwards the requester is the sole owner.
- R6: A write-miss to an exclusively owned line sends kind 3 (forward write) to the owner, and the requester becomes sole owner.
- R7: A miss to a tracked line that no other cache holds is served from the lower level, using kind 0 or 1 as for an untracked line.
- R8: An evict (req_type 2 or 3) clears the evicting cache's bit, and the entry becomes Invalid when no holder remains. An evict from a non-holder or to an untracked line changes nothing and sends no message.
- R9: Allocating into a set whose ways are all valid first sends kind 5 (recall) with the victim's address and holder mask, then the fetch message.
- R10: Invalid ways are filled before any valid entry is displaced. Otherwise the victim is the way least recently allocated or hit by a read-miss or write-miss. Evicts do not change the recency order.
- R11: After accepting a read-miss or write-miss, req_ready stays low until cmp_valid is seen with no message pending. An evict leaves req_ready high.
- R12: While msg_valid is high and msg_ready is low, every msg_* field holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Directory can accept a request |
| req_type | input | 2 | 0 read-miss, 1 write-miss, 2/3 evict |
| req_src | input | CID_W | Requesting cache id |
| req_addr | input | ADDR_W | Line address (low SET_W bits select the set) |
| msg_valid | output | 1 | Coherence message present |
| msg_ready | input | 1 | Fabric takes the message |
| msg_kind | output | 3 | 0 fetch-E, 1 fetch-M, 2 fwd-read, 3 fwd-write, 4 invalidate, 5 recall |
| msg_addr | output | ADDR_W | Line the message concerns |
| msg_dst | output | N_CACHE | Target caches (zero means the lower level) |
| msg_req | output | CID_W | Cache that receives the data or grant |
| cmp_valid | input | 1 | Completion of the outstanding transaction |

## Verification
The bench targets the choice of data supplier among several holders: a design that picked any bit but the lowest would forward to the wrong cache. It also checks that an invalidate mask leaves out the requester, since a wrong mask would make the writer kill its own copy. An upgrade by the only remaining holder is covered, because a design that forwarded there would send a message with an empty target. The bench checks that an evict from a non-holder is harmless and that evicts leave the recency order alone; a design that got either wrong would recall the wrong line when a full set overflows. Back-pressure and stalled requests during an open transaction show whether a message changes before it is taken and whether a second transaction slips in before completion.

// File: rtl/dir_coherence_ctrl.sv
module dir_coherence_ctrl #(
  parameter int N_CACHE = 4,
  parameter int ADDR_W  = 12,
  parameter int SET_W   = 2,
  parameter int WAYS    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [1:0]                 req_type,
  input  logic [$clog2(N_CACHE)-1:0] req_src,
  input  logic [ADDR_W-1:0]          req_addr,
  output logic                       msg_valid,
  input  logic                       msg_ready,
  output logic [2:0]                 msg_kind,
  output logic [ADDR_W-1:0]          msg_addr,
  output logic [N_CACHE-1:0]         msg_dst,
  output logic [$clog2(N_CACHE)-1:0] msg_req,
  input  logic                       cmp_valid
);
  localparam int CID_W = $clog2(N_CACHE);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - SET_W;
  localparam int IDX_W = SET_W + WAY_W;
  localparam int ENT   = WAYS << SET_W;

  typedef enum logic [2:0] {
    K_FETCH_E = 3'd0, K_FETCH_M = 3'd1, K_FWD_RD = 3'd2,
    K_FWD_WR  = 3'd3, K_INV     = 3'd4, K_RECALL = 3'd5
  } kind_t;
  typedef enum logic [1:0] {ST_IDLE, ST_REC, ST_MSG, ST_WAIT} st_t;

  st_t                st;
  logic               e_v   [ENT];
  logic               e_mod [ENT];
  logic [TAG_W-1:0]   e_tag [ENT];
  logic [N_CACHE-1:0] e_shr [ENT];
  logic [WAY_W-1:0]   e_age [ENT];

  kind_t              m_kind;
  logic [ADDR_W-1:0]  m_addr, v_addr;
  logic [N_CACHE-1:0] m_dst, v_dst;
  logic [CID_W-1:0]   m_req;

  logic [SET_W-1:0]   set_i;
  logic [TAG_W-1:0]   tag_i;
  logic               hit, free, hm, accept;
  logic [WAY_W-1:0]   hway, fway, lway, tway;
  logic [IDX_W-1:0]   hidx, tidx;
  logic [N_CACHE-1:0] rbit, hs, others, low;

  assign set_i  = req_addr[SET_W-1:0];
  assign tag_i  = req_addr[ADDR_W-1:SET_W];
  assign req_ready = (st == ST_IDLE);
  assign accept = req_valid && req_ready;

  always_comb begin
    hit = 1'b0; free = 1'b0;
    hway = '0; fway = '0; lway = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (e_v[{set_i, WAY_W'(w)}] && e_tag[{set_i, WAY_W'(w)}] == tag_i) begin
        hit = 1'b1; hway = WAY_W'(w);
      end
      if (!e_v[{set_i, WAY_W'(w)}] && !free) begin
        free = 1'b1; fway = WAY_W'(w);
      end
      if (e_age[{set_i, WAY_W'(w)}] == WAY_W'(WAYS - 1)) lway = WAY_W'(w);
    end
  end

  assign hidx   = {set_i, hway};
  assign tway   = hit ? hway : (free ? fway : lway);
  assign tidx   = {set_i, tway};
  assign hs     = hit ? e_shr[hidx] : '0;
  assign hm     = hit && e_mod[hidx];
  assign rbit   = N_CACHE'(1) << req_src;
  assign others = hs & ~rbit;
  assign low    = others & (~others + N_CACHE'(1));

  kind_t              d_kind;
  logic [N_CACHE-1:0] d_dst, d_shr;
  logic               d_mod, d_rec;

  always_comb begin
    d_kind = req_type[0] ? K_FETCH_M : K_FETCH_E;
    d_dst  = '0;
    d_shr  = rbit;
    d_mod  = 1'b1;
    d_rec  = 1'b0;
    if (!hit) begin
      d_rec = !free;
    end else if (others != '0) begin
      if (!req_type[0]) begin
        d_kind = K_FWD_RD; d_dst = low; d_shr = hs | rbit; d_mod = 1'b0;
      end else begin
        d_kind = hm ? K_FWD_WR : K_INV; d_dst = others;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      for (int i = 0; i < ENT; i++) begin
        e_v[i]   <= 1'b0;
        e_mod[i] <= 1'b0;
        e_tag[i] <= '0;
        e_shr[i] <= '0;
        e_age[i] <= WAY_W'(i % WAYS);
      end
      m_kind <= K_FETCH_E; m_addr <= '0; m_dst <= '0; m_req <= '0;
      v_addr <= '0; v_dst <= '0;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          if (req_type[1]) begin
            if (hit) begin
              e_shr[hidx] <= others;
              if (others == '0) e_v[hidx] <= 1'b0;
            end
          end else begin
            e_v[tidx]   <= 1'b1;
            e_tag[tidx] <= tag_i;
            e_shr[tidx] <= d_shr;
            e_mod[tidx] <= d_mod;
            for (int w = 0; w < WAYS; w++) begin
              if (WAY_W'(w) == tway)
                e_age[{set_i, WAY_W'(w)}] <= '0;
              else if (e_age[{set_i, WAY_W'(w)}] < e_age[tidx])
                e_age[{set_i, WAY_W'(w)}] <= e_age[{set_i, WAY_W'(w)}] + WAY_W'(1);
            end
            m_kind <= d_kind; m_addr <= req_addr; m_dst <= d_dst; m_req <= req_src;
            v_addr <= {e_tag[tidx], set_i};
            v_dst  <= e_shr[tidx];
            st     <= d_rec ? ST_REC : ST_MSG;
          end
        end
        ST_REC:  if (msg_ready) st <= ST_MSG;
        ST_MSG:  if (msg_ready) st <= ST_WAIT;
        default: if (cmp_valid) st <= ST_IDLE;
      endcase
    end
  end

  assign msg_valid = (st == ST_REC) || (st == ST_MSG);
  assign msg_kind  = (st == ST_REC) ? K_RECALL : m_kind;
  assign msg_addr  = (st == ST_REC) ? v_addr : m_addr;
  assign msg_dst   = (st == ST_REC) ? v_dst : m_dst;
  assign msg_req   = m_req;

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_kind) && $stable(msg_addr)
                                && $stable(msg_dst) && $stable(msg_req));
  a_r11_block: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_type[1] |=> !req_ready && msg_valid);
  a_r11_evict_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_type[1] |=> req_ready && !msg_valid);
  a_r2_fwd_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && (msg_kind == K_FWD_RD || msg_kind == K_FWD_WR) |-> $countones(msg_dst) == 1);
  a_r1_fetch_lower: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && (msg_kind == K_FETCH_E || msg_kind == K_FETCH_M) |-> msg_dst == '0);
  a_r5_inv_excl: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_kind == K_INV |-> msg_dst != '0 && !msg_dst[msg_req]);
  a_r9_recall_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_ready && msg_kind == K_RECALL |=>
      msg_valid && (msg_kind == K_FETCH_E || msg_kind == K_FETCH_M));

  for (genvar g = 0; g < ENT; g++) begin : g_entry_chk
    a_r8_entry_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      e_v[g] |-> e_shr[g] != '0);
    a_r6_owner_single: assert property (@(posedge clk) disable iff (!rst_n)
      e_v[g] && e_mod[g] |-> $countones(e_shr[g]) == 1);
  end
endmodule

// File: tb/dir_coherence_ctrl_tb.sv
module dir_coherence_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 21;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready;
  logic [1:0]  req_type;
  logic [1:0]  req_src;
  logic [11:0] req_addr;
  logic        msg_valid, msg_ready;
  logic [2:0]  msg_kind;
  logic [11:0] msg_addr;
  logic [3:0]  msg_dst;
  logic [1:0]  msg_req;
  logic        cmp_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dir_coherence_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type),
    .req_src(req_src), .req_addr(req_addr),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
    .msg_addr(msg_addr), .msg_dst(msg_dst), .msg_req(msg_req),
    .cmp_valid(cmp_valid)
  );

  // op[39:38] src[37:36] addr[35:24] kind[23:21] dst[20:17] rec[16] raddr[15:4] rdst[3:0]
  localparam logic [39:0] VEC [NVEC] = '{
    {2'd0, 2'd0, 12'h010, 3'd0, 4'b0000, 1'b0, 12'h000, 4'h0}, // R1 miss
    {2'd0, 2'd1, 12'h010, 3'd2, 4'b0001, 1'b0, 12'h000, 4'h0}, // R3 owner forward
    {2'd0, 2'd3, 12'h010, 3'd2, 4'b0001, 1'b0, 12'h000, 4'h0}, // R2 lowest holder
    {2'd1, 2'd1, 12'h010, 3'd4, 4'b1001, 1'b0, 12'h000, 4'h0}, // R5 inval others
    {2'd0, 2'd2, 12'h010, 3'd2, 4'b0010, 1'b0, 12'h000, 4'h0}, // R5 sole owner, R3
    {2'd2, 2'd1, 12'h010, 3'd7, 4'b0000, 1'b0, 12'h000, 4'h0}, // R8 evict holder
    {2'd1, 2'd2, 12'h010, 3'd1, 4'b0000, 1'b0, 12'h000, 4'h0}, // R7 lone upgrade
    {2'd1, 2'd0, 12'h010, 3'd3, 4'b0100, 1'b0, 12'h000, 4'h0}, // R6 fwd write
    {2'd2, 2'd3, 12'h010, 3'd7, 4'b0000, 1'b0, 12'h000, 4'h0}, // R8 non-holder
    {2'd2, 2'd0, 12'h010, 3'd7, 4'b0000, 1'b0, 12'h000, 4'h0}, // R8 last holder
    {2'd0, 2'd1, 12'h010, 3'd0, 4'b0000, 1'b0, 12'h000, 4'h0}, // R8 now invalid, R10 free way
    {2'd1, 2'd3, 12'h020, 3'd1, 4'b0000, 1'b0, 12'h000, 4'h0}, // R4 write miss
    {2'd0, 2'd0, 12'h001, 3'd0, 4'b0000, 1'b0, 12'h000, 4'h0}, // R10 fill set 1
    {2'd0, 2'd1, 12'h005, 3'd0, 4'b0000, 1'b0, 12'h000, 4'h0},
    {2'd0, 2'd2, 12'h009, 3'd0, 4'b0000, 1'b0, 12'h000, 4'h0},
    {2'd0, 2'd3, 12'h00D, 3'd0, 4'b0000, 1'b0, 12'h000, 4'h0},
    {2'd0, 2'd1, 12'h001, 3'd2, 4'b0001, 1'b0, 12'h000, 4'h0}, // R10 touch 0x001
    {2'd2, 2'd1, 12'h009, 3'd7, 4'b0000, 1'b0, 12'h000, 4'h0}, // R10 evict no touch
    {2'd1, 2'd2, 12'h011, 3'd1, 4'b0000, 1'b1, 12'h005, 4'b0010}, // R9 recall LRU
    {2'd0, 2'd0, 12'h005, 3'd0, 4'b0000, 1'b1, 12'h009, 4'b0100}, // R9 R10 next LRU
    {2'd1, 2'd0, 12'h001, 3'd4, 4'b0010, 1'b0, 12'h000, 4'h0}  // R5 excl requester
  };

  task automatic chk(input string tag, input int step, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s step=%0d act=%0h exp=%0h", tag, step, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] k);
    case (k)
      3'd0: return "R1/R7";
      3'd1: return "R4/R7";
      3'd2: return "R2/R3";
      3'd3: return "R6";
      default: return "R5";
    endcase
  endfunction

  task automatic complete(input int step);
    @(negedge clk);
    chk("R11 busy ready", step, 32'(req_ready), 32'd0);
    chk("R11 one message", step, 32'(msg_valid), 32'd0);
    cmp_valid = 1'b1;
    @(negedge clk);
    cmp_valid = 1'b0;
    chk("R11 ready after cmp", step, 32'(req_ready), 32'd1);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    logic [39:0] v;
    logic [2:0]  hk;
    logic [11:0] ha;
    logic [3:0]  hd;
    rst_n = 1'b0; req_valid = 1'b0; req_type = '0; req_src = '0; req_addr = '0;
    msg_ready = 1'b1; cmp_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset ready", -1, 32'(req_ready), 32'd1);
    chk("R12 reset idle msg", -1, 32'(msg_valid), 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      v = VEC[i];
      req_type = v[39:38]; req_src = v[37:36]; req_addr = v[35:24]; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      if (v[39]) begin
        chk("R8 evict sends nothing", i, 32'(msg_valid), 32'd0);
        chk("R11 evict keeps ready", i, 32'(req_ready), 32'd1);
      end else begin
        if (v[16]) begin
          chk("R9 recall kind", i, 32'(msg_kind), 32'd5);
          chk("R9 recall addr", i, 32'(msg_addr), 32'(v[15:4]));
          chk("R9 recall dst", i, 32'(msg_dst), 32'(v[3:0]));
          @(negedge clk);
        end
        chk(tag_of(v[23:21]), i, 32'(msg_valid), 32'd1);
        chk(tag_of(v[23:21]), i, 32'(msg_kind), 32'(v[23:21]));
        chk(tag_of(v[23:21]), i, 32'(msg_dst), 32'(v[20:17]));
        chk(tag_of(v[23:21]), i, 32'(msg_addr), 32'(v[35:24]));
        chk(tag_of(v[23:21]), i, 32'(msg_req), 32'(v[37:36]));
        complete(i);
      end
    end

    // R12: back-pressure on a fresh read-miss to set 3
    msg_ready = 1'b0;
    req_type = 2'd0; req_src = 2'd2; req_addr = 12'h003; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    hk = msg_kind; ha = msg_addr; hd = msg_dst;
    chk("R1 stalled fetch kind", 100, 32'(msg_kind), 32'd0);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R12 valid held", 100 + c, 32'(msg_valid), 32'd1);
      chk("R12 kind held", 100 + c, 32'(msg_kind), 32'(hk));
      chk("R12 addr held", 100 + c, 32'(msg_addr), 32'(ha));
      chk("R12 dst held", 100 + c, 32'(msg_dst), 32'(hd));
    end
    msg_ready = 1'b1;
    @(negedge clk);
    chk("R12 taken", 104, 32'(msg_valid), 32'd0);

    // R11: a second request waits for the completion
    req_type = 2'd0; req_src = 2'd0; req_addr = 12'h003; req_valid = 1'b1;
    for (int c = 0; c < 3; c++) begin
      chk("R11 stalled ready", 110 + c, 32'(req_ready), 32'd0);
      chk("R11 no early message", 110 + c, 32'(msg_valid), 32'd0);
      @(negedge clk);
    end
    cmp_valid = 1'b1;
    @(negedge clk);
    cmp_valid = 1'b0;
    chk("R11 ready after cmp", 113, 32'(req_ready), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R3 queued read kind", 114, 32'(msg_kind), 32'd2);
    chk("R3 queued read dst", 114, 32'(msg_dst), 32'b0100);
    chk("R3 queued read req", 114, 32'(msg_req), 32'd0);
    complete(115);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired act=0 exp=1");
      summary();
      $finish;
    end
  end
endmodule